// File: doc/BRIEF.md
# Four-Line Serial Multiplexer Register Front End

This block is the register interface between a word-wide peripheral bus and the inner logic of a four-line asynchronous serial multiplexer. It decodes four word offsets. Two of them reach different registers depending on direction. Reads at word index 1 return the head of the receive silo, and writes there load the line parameters. Reads at word index 3 return modem lead status, and writes there load a transmit character or the break bits. Writes can target the low byte lane, the high byte lane, or both.

The block keeps the control/status bits and the transmitter control bits. It issues strobes to the receive silo, the transmit scanner and the line parameter store. It forms the receiver and transmitter interrupt requests. A command bit starts a self-clearing device initialise. While that sequence runs it reads back as busy and clears the state selectively. A small state machine sequences the initialise. It has two named states: `ST_RUN`, normal operation, and `ST_INIT`, the initialise in progress. There are two transitions. `ST_RUN -> ST_INIT` fires on an initialise command. `ST_INIT -> ST_RUN` fires when the cycle counter reaches zero. A second counter tracks silo fill for the alarm flag.

Top module: `smx_reg_front`

## Requirements
- R1: `bus_off` is a word index. A read at index 0 returns control/status (CSR), index 1 the receive buffer word, index 2 the transmitter control word, and index 3 modem status. A write at index 0 loads CSR, index 1 line parameters, index 2 transmitter control, and index 3 transmit data/break.
- R2: `bus_be[0]` enables the low byte (bits 7:0) and `bus_be[1]` enables the high byte (bits 15:8). Only the CSR bits 3, 5, 6, 12 and 14 are writable. Writes to CSR bits 7, 8, 9, 13 and 15 are ignored, and the remaining CSR bits read as zero.
- R3: CSR bit 3 (loopback) drives the `maint` output.
- R4: A write with the low lane enabled and bit 4 set starts an initialise, and the other bits of that write are discarded. CSR bit 4 reads 1 and `init_pulse` is high for exactly INIT_CYCLES (16) cycles, starting the cycle after the write.
- R5: An initialise clears the writable CSR bits, the transmitter enable bits, the break bits and the silo alarm, starting with the command's own clock edge. It keeps the terminal-ready bits. Register writes are ignored while it runs.
- R6: Bus reset (`rst_n` low) clears all state, including the terminal-ready bits.
- R7: The receive buffer word is {valid, `rx_head`[14:0]}. Valid equals `rx_head_valid` AND scan enable AND NOT initialising, and CSR bit 7 (receiver done) mirrors it. A read at index 1 pulses `rx_pop` only when valid is set.
- R8: When CSR bit 5 (scan enable) is clear, or an initialise runs, `silo_flush` is high and CSR bits 7 and 15 read 0.
- R9: With CSR bit 12 set, `rx_push` pulses are counted, and CSR bit 13 (silo alarm) sets on the 16th. A read at index 1 clears both the count and the alarm. With bit 12 clear, the count and the alarm are held at zero.
- R10: CSR bit 15 (transmitter ready) is scan enable AND `tx_rdy_in` AND the transmitter enable bit of line `tx_line_in`. CSR bits 9:8 show `tx_line_in` while bit 15 is set and read 0 otherwise.
- R11: `rx_irq` = bit 6 AND (bit 13 if bit 12 is set, otherwise bit 7). `tx_irq` = bit 14 AND bit 15.
- R12: A low-lane write at index 3 pulses `tx_load` with `tx_char` = wdata[7:0] and `tx_load_line` = `tx_line_in`. A high-lane write at index 3 loads `brk` from wdata[11:8].
- R13: Modem status reads `ring` in bits 3:0 and `carrier` in bits 11:8, with all other bits 0. The transmitter control word reads the enables in bits 3:0 and terminal-ready in bits 11:8, with all other bits 0.
- R14: A write at index 1 pulses `lpr_wr` (with `lpr_data` = wdata) only when both lanes are enabled. Partial-lane writes there have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous bus reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_off | input | 2 | Word index of the register |
| bus_be | input | 2 | Byte lane enables (bit 0 low byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| rx_head_valid | input | 1 | Silo head holds a character |
| rx_head | input | 15 | Silo head character and error flags |
| rx_push | input | 1 | Silo accepted a character |
| rx_pop | output | 1 | Remove the silo head |
| silo_flush | output | 1 | Empty the silo |
| tx_rdy_in | input | 1 | Scanner stopped on a line that needs a character |
| tx_line_in | input | 2 | Line the scanner stopped on |
| tx_load | output | 1 | Transmit character strobe |
| tx_char | output | 8 | Transmit character |
| tx_load_line | output | 2 | Line for the transmit character |
| lpr_wr | output | 1 | Line parameter load strobe |
| lpr_data | output | 16 | Line parameter word |
| carrier | input | 4 | Carrier detect per line |
| ring | input | 4 | Ring indicator per line |
| tcr_en | output | 4 | Transmitter enable per line |
| dtr | output | 4 | Terminal ready per line |
| brk | output | 4 | Force line to space |
| maint | output | 1 | Loopback mode |
| scan_en | output | 1 | Scanning enabled |
| init_pulse | output | 1 | Device initialise in progress |
| rx_irq | output | 1 | Receiver interrupt request |
| tx_irq | output | 1 | Transmitter interrupt request |

## Verification
The embedded properties check on every cycle that the initialise sequence keeps running until its counter reaches zero and starts from the full count. They also check that it clears the transmit enables, breaks and scan enable while leaving terminal-ready untouched, and that the silo alarm stays clear while counting is disabled or after a buffer read. Further properties check that pops and transmit interrupts never appear without their enabling conditions. Other behaviours can only be shown by the bench's scenarios: the exact 16-cycle busy window, byte-lane masking, the split read/write meaning of indexes 1 and 3, the alarm on exactly the 16th push, and the interrupt mode switch.

// File: rtl/smx_pkg.sv
package smx_pkg;
    typedef enum logic { ST_RUN = 1'b0, ST_INIT = 1'b1 } init_st_t;

    localparam int LIDX = 2;

    localparam logic [1:0] IDX_CSR  = 2'd0;
    localparam logic [1:0] IDX_RBUF = 2'd1;
    localparam logic [1:0] IDX_TCR  = 2'd2;
    localparam logic [1:0] IDX_MSR  = 2'd3;

    localparam int B_MAINT = 3;
    localparam int B_INIT  = 4;
    localparam int B_SCAN  = 5;
    localparam int B_RIE   = 6;
    localparam int B_RDONE = 7;
    localparam int B_LINE  = 8;
    localparam int B_SAE   = 12;
    localparam int B_ALARM = 13;
    localparam int B_TIE   = 14;
    localparam int B_TRDY  = 15;
    localparam int HI_LANE = 8;
endpackage

// File: rtl/smx_init_seq.sv
module smx_init_seq #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    import smx_pkg::*;

    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    init_st_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (start) begin
                    state_d = ST_INIT;
                    cnt_d   = LAST;
                end
            end
            ST_INIT: begin
                if (cnt_q == '0) begin
                    state_d = ST_RUN;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        busy = (state_q == ST_INIT);
    end

    // R4: the sequence keeps running until its counter is exhausted
    a_r4_init_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT && cnt_q != '0) |=> (state_q == ST_INIT));

    // R4: a start from idle loads the full count
    a_r4_init_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && start) |=> (state_q == ST_INIT && cnt_q == LAST));
endmodule

// File: rtl/smx_silo_alarm.sv
module smx_silo_alarm #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic clr,
    input  logic push,
    input  logic rd_clr,
    output logic alarm
);
    localparam int CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] TOP = CW'(DEPTH - 1);

    logic [CW-1:0] cnt_q;
    logic          alarm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            alarm_q <= 1'b0;
        end else if (!enable || clr || rd_clr) begin
            cnt_q   <= '0;
            alarm_q <= 1'b0;
        end else if (push) begin
            if (cnt_q == TOP) begin
                cnt_q   <= '0;
                alarm_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign alarm = alarm_q;

    // R9: alarm is held clear while counting is disabled
    a_r9_alarm_held: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !alarm);

    // R9: a buffer read drops the alarm
    a_r9_alarm_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> !alarm);
endmodule

// File: rtl/smx_rd_mux.sv
module smx_rd_mux (
    input  logic [1:0]  idx,
    input  logic [15:0] csr_word,
    input  logic [15:0] rbuf_word,
    input  logic [15:0] tcr_word,
    input  logic [15:0] msr_word,
    output logic [15:0] rdata
);
    import smx_pkg::*;

    always_comb begin
        unique case (idx)
            IDX_CSR:  rdata = csr_word;
            IDX_RBUF: rdata = rbuf_word;
            IDX_TCR:  rdata = tcr_word;
            IDX_MSR:  rdata = msr_word;
        endcase
    end
endmodule

// File: rtl/smx_reg_front.sv
module smx_reg_front #(
    parameter int LINES       = 4,
    parameter int INIT_CYCLES = 16,
    parameter int ALARM_DEPTH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [1:0]              bus_off,
    input  logic [1:0]              bus_be,
    input  logic [15:0]             bus_wdata,
    output logic [15:0]             bus_rdata,
    input  logic                    rx_head_valid,
    input  logic [14:0]             rx_head,
    input  logic                    rx_push,
    output logic                    rx_pop,
    output logic                    silo_flush,
    input  logic                    tx_rdy_in,
    input  logic [smx_pkg::LIDX-1:0] tx_line_in,
    output logic                    tx_load,
    output logic [7:0]              tx_char,
    output logic [smx_pkg::LIDX-1:0] tx_load_line,
    output logic                    lpr_wr,
    output logic [15:0]             lpr_data,
    input  logic [LINES-1:0]        carrier,
    input  logic [LINES-1:0]        ring,
    output logic [LINES-1:0]        tcr_en,
    output logic [LINES-1:0]        dtr,
    output logic [LINES-1:0]        brk,
    output logic                    maint,
    output logic                    scan_en,
    output logic                    init_pulse,
    output logic                    rx_irq,
    output logic                    tx_irq
);
    import smx_pkg::*;

    localparam int LW = LINES;

    logic busy, init_req, clr_now;
    logic wr_ok, lo, hi;
    logic maint_q, scan_q, rie_q, sae_q, tie_q;
    logic [LW-1:0] ten_q, dtr_q, brk_q;
    logic rx_valid, tx_ready, alarm, rbuf_rd;
    logic [15:0] csr_word, rbuf_word, tcr_word, msr_word;

    assign lo       = bus_be[0];
    assign hi       = bus_be[1];
    assign wr_ok    = bus_wr && !busy;
    assign init_req = wr_ok && bus_off == IDX_CSR && lo && bus_wdata[B_INIT];
    assign clr_now  = init_req || busy;

    smx_init_seq #(.CYCLES(INIT_CYCLES)) u_init (
        .clk   (clk),
        .rst_n (rst_n),
        .start (init_req),
        .busy  (busy)
    );

    // control/status writable bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            maint_q <= 1'b0; scan_q <= 1'b0; rie_q <= 1'b0;
            sae_q   <= 1'b0; tie_q  <= 1'b0;
        end else if (clr_now) begin
            maint_q <= 1'b0; scan_q <= 1'b0; rie_q <= 1'b0;
            sae_q   <= 1'b0; tie_q  <= 1'b0;
        end else if (wr_ok && bus_off == IDX_CSR) begin
            if (lo) begin
                maint_q <= bus_wdata[B_MAINT];
                scan_q  <= bus_wdata[B_SCAN];
                rie_q   <= bus_wdata[B_RIE];
            end
            if (hi) begin
                sae_q <= bus_wdata[B_SAE];
                tie_q <= bus_wdata[B_TIE];
            end
        end
    end

    // transmitter enables (cleared by initialise) and terminal-ready (bus reset only)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ten_q <= '0;
            dtr_q <= '0;
        end else begin
            if (clr_now) begin
                ten_q <= '0;
            end else if (wr_ok && bus_off == IDX_TCR && lo) begin
                ten_q <= bus_wdata[LW-1:0];
            end
            if (wr_ok && !init_req && bus_off == IDX_TCR && hi) begin
                dtr_q <= bus_wdata[HI_LANE +: LW];
            end
        end
    end

    // break bits in the high lane of the transmit data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_q <= '0;
        end else if (clr_now) begin
            brk_q <= '0;
        end else if (wr_ok && bus_off == IDX_MSR && hi) begin
            brk_q <= bus_wdata[HI_LANE +: LW];
        end
    end

    assign rbuf_rd = bus_rd && bus_off == IDX_RBUF;

    smx_silo_alarm #(.DEPTH(ALARM_DEPTH)) u_alarm (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (sae_q),
        .clr    (clr_now),
        .push   (rx_push),
        .rd_clr (rbuf_rd),
        .alarm  (alarm)
    );

    assign rx_valid = rx_head_valid && scan_q && !busy;
    assign tx_ready = scan_q && !busy && tx_rdy_in && ten_q[tx_line_in];

    always_comb begin
        csr_word = '0;
        csr_word[B_MAINT] = maint_q;
        csr_word[B_INIT]  = busy;
        csr_word[B_SCAN]  = scan_q;
        csr_word[B_RIE]   = rie_q;
        csr_word[B_RDONE] = rx_valid;
        csr_word[B_LINE +: LIDX] = tx_ready ? tx_line_in : '0;
        csr_word[B_SAE]   = sae_q;
        csr_word[B_ALARM] = alarm;
        csr_word[B_TIE]   = tie_q;
        csr_word[B_TRDY]  = tx_ready;

        rbuf_word = {rx_valid, rx_head};

        tcr_word = '0;
        tcr_word[LW-1:0]       = ten_q;
        tcr_word[HI_LANE +: LW] = dtr_q;

        msr_word = '0;
        msr_word[LW-1:0]       = ring;
        msr_word[HI_LANE +: LW] = carrier;
    end

    smx_rd_mux u_mux (
        .idx       (bus_off),
        .csr_word  (csr_word),
        .rbuf_word (rbuf_word),
        .tcr_word  (tcr_word),
        .msr_word  (msr_word),
        .rdata     (bus_rdata)
    );

    assign rx_pop       = rbuf_rd && rx_valid;
    assign silo_flush   = !scan_q || busy;
    assign tx_load      = wr_ok && bus_off == IDX_MSR && lo;
    assign tx_char      = bus_wdata[7:0];
    assign tx_load_line = tx_line_in;
    assign lpr_wr       = wr_ok && bus_off == IDX_RBUF && lo && hi;
    assign lpr_data     = bus_wdata;
    assign tcr_en       = ten_q;
    assign dtr          = dtr_q;
    assign brk          = brk_q;
    assign maint        = maint_q;
    assign scan_en      = scan_q;
    assign init_pulse   = busy;
    assign rx_irq       = rie_q && (sae_q ? alarm : rx_valid);
    assign tx_irq       = tie_q && tx_ready;

    // R5: an initialise cycle leaves enables, breaks and scan cleared
    a_r5_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> (tcr_en == '0 && brk == '0 && !scan_en));

    // R5: terminal-ready survives the initialise
    a_r5_dtr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> $stable(dtr));

    // R7: a pop is only issued for a valid head while scanning
    a_r7_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (rx_head_valid && scan_en));

    // R11: transmitter request needs a stopped scanner while scanning
    a_r11_tx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (tx_rdy_in && scan_en && !init_pulse));
endmodule

// File: tb/tb_smx_reg_front.sv
module tb_smx_reg_front;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 0, bus_rd = 0;
    logic [1:0] bus_off = 0, bus_be = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic rx_head_valid = 0;
    logic [14:0] rx_head = 0;
    logic rx_push = 0;
    logic rx_pop, silo_flush;
    logic tx_rdy_in = 0;
    logic [1:0] tx_line_in = 0;
    logic tx_load;
    logic [7:0] tx_char;
    logic [1:0] tx_load_line;
    logic lpr_wr;
    logic [15:0] lpr_data;
    logic [3:0] carrier = 4'b1010, ring = 4'b0101;
    logic [3:0] tcr_en, dtr, brk;
    logic maint, scan_en, init_pulse, rx_irq, tx_irq;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    smx_reg_front dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_off(bus_off), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_head_valid(rx_head_valid), .rx_head(rx_head),
        .rx_push(rx_push), .rx_pop(rx_pop), .silo_flush(silo_flush),
        .tx_rdy_in(tx_rdy_in), .tx_line_in(tx_line_in), .tx_load(tx_load),
        .tx_char(tx_char), .tx_load_line(tx_load_line), .lpr_wr(lpr_wr),
        .lpr_data(lpr_data), .carrier(carrier), .ring(ring), .tcr_en(tcr_en),
        .dtr(dtr), .brk(brk), .maint(maint), .scan_en(scan_en),
        .init_pulse(init_pulse), .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    // {write, write index, lanes, wdata, read index, expected read}
    localparam int NV = 10;
    localparam logic [38:0] VEC [NV] = '{
        {1'b1, 2'd0, 2'd3, 16'h5068, 2'd0, 16'h5068},
        {1'b1, 2'd0, 2'd1, 16'h0000, 2'd0, 16'h5000},
        {1'b1, 2'd0, 2'd2, 16'hFFFF, 2'd0, 16'h5000},
        {1'b1, 2'd0, 2'd1, 16'hFFEF, 2'd0, 16'h5068},
        {1'b1, 2'd2, 2'd3, 16'h0A05, 2'd2, 16'h0A05},
        {1'b1, 2'd2, 2'd1, 16'h00FF, 2'd2, 16'h0A0F},
        {1'b1, 2'd2, 2'd2, 16'hFF00, 2'd2, 16'h0F0F},
        {1'b0, 2'd0, 2'd0, 16'h0000, 2'd3, 16'h0A05},
        {1'b0, 2'd0, 2'd0, 16'h0000, 2'd1, 16'h0000},
        {1'b1, 2'd0, 2'd3, 16'h0000, 2'd0, 16'h0000}
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] off, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1; bus_off = off; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_be = 0;
    endtask

    task automatic peek(input logic [1:0] off, output logic [15:0] d);
        bus_off = off;
        #1 d = bus_rdata;
    endtask

    task automatic rd(input logic [1:0] off, output logic [15:0] d, output logic pop);
        @(negedge clk);
        bus_rd = 1; bus_off = off;
        #1 d = bus_rdata; pop = rx_pop;
        @(negedge clk);
        bus_rd = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic p;
        repeat (3) @(negedge clk);
        peek(2'd0, v); chk("R6 reset csr", v, 16'h0000);
        peek(2'd2, v); chk("R6 reset tcr", v, 16'h0000);
        rst_n = 1;

        // R1 R2 R13 table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][38]) wr(VEC[i][37:36], VEC[i][35:34], VEC[i][33:18]);
            peek(VEC[i][17:16], v);
            chk($sformatf("R1/R2/R13 vec %0d", i), v, VEC[i][15:0]);
        end

        // R3 loopback output
        wr(2'd0, 2'd1, 16'h0008);
        chk("R3 maint", {15'd0, maint}, 16'd1);

        // R14 line parameter writes
        @(negedge clk);
        bus_wr = 1; bus_off = 2'd1; bus_be = 2'd1; bus_wdata = 16'h1A2B;
        #1 chk("R14 partial ignored", {15'd0, lpr_wr}, 16'd0);
        bus_be = 2'd3;
        #1 chk("R14 word strobe", {15'd0, lpr_wr}, 16'd1);
        chk("R14 word data", lpr_data, 16'h1A2B);
        @(negedge clk); bus_wr = 0; bus_be = 0;

        // R7 receive head
        wr(2'd0, 2'd1, 16'h0060);
        rx_head_valid = 1; rx_head = 15'h1234;
        peek(2'd0, v); chk("R7 rx done", v, 16'h00E0);
        chk("R11 rx irq char mode", {15'd0, rx_irq}, 16'd1);
        rd(2'd1, v, p);
        chk("R7 rbuf word", v, 16'h9234);
        chk("R7 pop", {15'd0, p}, 16'd1);

        // R8 scan off
        wr(2'd0, 2'd1, 16'h0040);
        rd(2'd1, v, p);
        chk("R8 rbuf invalid", v, 16'h1234);
        chk("R8 no pop", {15'd0, p}, 16'd0);
        chk("R8 flush", {15'd0, silo_flush}, 16'd1);
        rx_head_valid = 0;

        // R9 silo alarm
        wr(2'd0, 2'd3, 16'h1060);
        @(negedge clk); rx_push = 1;
        repeat (15) @(negedge clk);
        rx_push = 0;
        peek(2'd0, v); chk("R9 no alarm at 15", v, 16'h1060);
        @(negedge clk); rx_push = 1;
        @(negedge clk); rx_push = 0;
        peek(2'd0, v); chk("R9 alarm at 16", v, 16'h3060);
        chk("R11 rx irq alarm mode", {15'd0, rx_irq}, 16'd1);
        rd(2'd1, v, p);
        peek(2'd0, v); chk("R9 read clears", v, 16'h1060);

        // R10 R11 R12 transmit side
        wr(2'd0, 2'd3, 16'h4020);
        wr(2'd2, 2'd1, 16'h0004);
        tx_rdy_in = 1; tx_line_in = 2'd2;
        peek(2'd0, v); chk("R10 ready and line", v, 16'hC220);
        chk("R11 tx irq", {15'd0, tx_irq}, 16'd1);
        @(negedge clk);
        bus_wr = 1; bus_off = 2'd3; bus_be = 2'd1; bus_wdata = 16'h0041;
        #1 chk("R12 load", {15'd0, tx_load}, 16'd1);
        chk("R12 char", {8'd0, tx_char}, 16'h0041);
        chk("R12 line", {14'd0, tx_load_line}, 16'd2);
        @(negedge clk); bus_wr = 0; bus_be = 0;
        wr(2'd2, 2'd1, 16'h0000);
        peek(2'd0, v); chk("R10 enable cleared", v, 16'h4020);
        chk("R11 tx irq off", {15'd0, tx_irq}, 16'd0);
        @(negedge clk);
        bus_wr = 1; bus_off = 2'd3; bus_be = 2'd2; bus_wdata = 16'h0500;
        #1 chk("R12 no load on high lane", {15'd0, tx_load}, 16'd0);
        @(negedge clk); bus_wr = 0; bus_be = 0;
        chk("R12 break bits", {12'd0, brk}, 16'h0005);
        tx_rdy_in = 0;

        // R4 R5 initialise
        wr(2'd0, 2'd3, 16'h5068);
        wr(2'd2, 2'd3, 16'h0F0F);
        wr(2'd0, 2'd1, 16'h0010);
        peek(2'd0, v); chk("R4 busy readback", v, 16'h0010);
        chk("R4 init pulse", {15'd0, init_pulse}, 16'd1);
        wr(2'd0, 2'd1, 16'h0020);
        repeat (13) @(negedge clk);
        peek(2'd0, v); chk("R4 busy at cycle 16", v, 16'h0010);
        chk("R5 write ignored", {15'd0, scan_en}, 16'd0);
        @(negedge clk);
        peek(2'd0, v); chk("R4 self clear", v, 16'h0000);
        peek(2'd2, v); chk("R5 dtr kept", v, 16'h0F00);
        chk("R5 break cleared", {12'd0, brk}, 16'h0000);

        // R6 bus reset clears terminal-ready
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        peek(2'd2, v); chk("R6 dtr cleared", v, 16'h0000);
        rst_n = 1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule